// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block collects the interrupt events of a CAN protocol controller into one 8-bit status register. The CPU reads that register at address 3. Five event sources feed it: a received frame, a released transmit buffer, a change in the error or bus condition, an overrun of the two-slot receive buffer, and the end of sleep. Each source has its own set rule. Four of the sources also need their enable input high. While any flag is set, one interrupt line to the CPU stays high. A single read of the register clears all the flags at once.

The block keeps its own count of how many of the two receive slots are in use. It does this with a small state machine, so it can tell a normal arrival from an overrun. The machine has three states: `OCC_EMPTY`, `OCC_ONE` and `OCC_FULL`.
- An accept strobe moves it from `OCC_EMPTY` to `OCC_ONE`, and from `OCC_ONE` to `OCC_FULL`.
- A release strobe moves it from `OCC_FULL` to `OCC_ONE`, and from `OCC_ONE` to `OCC_EMPTY`.
- An accept strobe in `OCC_FULL` is an overrun, and the state does not change.
- Accept and release together keep `OCC_ONE` where it is.
- Accept and release together in `OCC_EMPTY` go to `OCC_ONE`.
- Accept and release together in `OCC_FULL` go to `OCC_ONE`, and the accept still counts as an overrun.
- All other input combinations leave the state unchanged.

The enable bits, bit timing and frame decoding belong to other parts of the controller. They reach this block only as input signals.

Top module: `can_irq_flags`

## Requirements
- R1: The register layout is: receive flag at bit 0, transmit flag at bit 1, error flag at bit 2, overrun flag at bit 3 and wake-up flag at bit 4. Bits 7..5 always read 0.
- R2: `irq` is high in every cycle in which at least one flag is set.
- R3: A read (`cpu_rd` high with `cpu_addr` = 3) clears every flag on the clock edge that ends the read cycle. The register has no write path.
- R4: The wake-up flag sets on a high-to-low transition of `sleep_lvl`. It has no enable.
- R5: The transmit flag sets only on a low-to-high transition of `txbuf_free`, and only while `en_tx` is high.
- R6: The error flag sets on any change of `err_stat` or `bus_stat`, and only while `en_err` is high.
- R7: When an accepted frame lands in a free slot and `en_rx` is high, the receive flag sets. It sets on the same edge on which `rxbuf_status` becomes high.
- R8: When `rx_accept` arrives while both slots are full, `data_ovr` sets. On the same edge the overrun flag also sets, provided `en_ovr` is high.
- R9: Slot occupancy runs from 0 to 2. `rx_accept` adds one below 2, and `rx_release` removes one above 0. `rxbuf_status` is high whenever the occupancy is nonzero.
- R10: If a set event falls in the same cycle as a clearing read, that event's flag is still set after the read.
- R11: During a read, `rd_data` shows the register value from before the clear. When the address is not 3, `rd_data` is 0 and no flag is cleared.
- R12: `data_ovr` stays high through register reads until an `ovr_clear` strobe arrives.
- R13: A synchronous `rst` clears all flags, the occupancy, `data_ovr` and the transition history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 3 | CPU register address |
| rd_data | output | 8 | Read data, flag register when address is 3 |
| irq | output | 1 | Interrupt request to CPU |
| en_rx | input | 1 | Receive interrupt enable |
| en_tx | input | 1 | Transmit interrupt enable |
| en_err | input | 1 | Error interrupt enable |
| en_ovr | input | 1 | Overrun interrupt enable |
| err_stat | input | 1 | Error status level |
| bus_stat | input | 1 | Bus status level |
| txbuf_free | input | 1 | Transmit buffer released level |
| sleep_lvl | input | 1 | Sleep mode level |
| rx_accept | input | 1 | Strobe: frame passed acceptance |
| rx_release | input | 1 | Strobe: receive slot released |
| ovr_clear | input | 1 | Strobe: clear data overrun status |
| rxbuf_status | output | 1 | Receive buffer holds a message |
| data_ovr | output | 1 | Data overrun status |

## Verification
The receive path is driven with every sequence of four accept/release strobe pairs, under all four settings of the receive and overrun enables. This separates a normal arrival from an overrun, and shows that the count saturates at both 0 and 2. For the error, transmit and sleep levels, the bench runs through every pair of before/after values, with the enable both high and low. These runs show that each flag responds only to its own kind of transition: any change, a rise, or a fall. Targeted cases then cover a read that coincides with a set event, a read at the wrong address, all five flags set together with the reserved bits still 0, and a reset that follows an overrun.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int DATA_W   = 8;
    localparam int FLAG_W   = 5;
    localparam int ADDR_W   = 3;
    localparam int REG_ADDR = 3;

    // flag bit positions (software decodes these)
    localparam int B_RX   = 0;
    localparam int B_TX   = 1;
    localparam int B_ERR  = 2;
    localparam int B_OVR  = 3;
    localparam int B_WAKE = 4;

    // level inputs tracked for transitions
    localparam int NLVL  = 4;
    localparam int L_ERR = 0;
    localparam int L_BUS = 1;
    localparam int L_TXB = 2;
    localparam int L_SLP = 3;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;
endpackage

// File: rtl/can_irq_lvl_hist.sv
module can_irq_lvl_hist #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    for (genvar i = 0; i < N; i++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b0;
            else     prev[i] <= lvl[i];
        end
    end
endmodule

// File: rtl/can_irq_rx_occ.sv
module can_irq_rx_occ
    import can_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc,
    input  logic rel,
    input  logic ovr_clr,
    output logic new_msg,
    output logic ovr_ev,
    output logic full,
    output logic buf_stat,
    output logic dov_stat
);
    occ_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= OCC_EMPTY;
        else     state <= state_nx;
    end

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            OCC_EMPTY: if (acc) state_nx = OCC_ONE;
            OCC_ONE: begin
                if (acc && !rel)      state_nx = OCC_FULL;
                else if (rel && !acc) state_nx = OCC_EMPTY;
            end
            OCC_FULL:  if (rel) state_nx = OCC_ONE;
            default:   state_nx = OCC_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        new_msg  = 1'b0;
        ovr_ev   = 1'b0;
        full     = 1'b0;
        buf_stat = 1'b1;
        unique case (state)
            OCC_EMPTY: begin
                new_msg  = acc;
                buf_stat = 1'b0;
            end
            OCC_ONE:   new_msg = acc;
            OCC_FULL: begin
                ovr_ev = acc;
                full   = 1'b1;
            end
            default:   buf_stat = 1'b0;
        endcase
    end

    // data overrun status: set wins over clear
    always_ff @(posedge clk) begin
        if (rst)          dov_stat <= 1'b0;
        else if (ovr_ev)  dov_stat <= 1'b1;
        else if (ovr_clr) dov_stat <= 1'b0;
    end
endmodule

// File: rtl/can_irq_flag_bank.sv
module can_irq_flag_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_hit,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (rd_hit ? '0 : flags) | set_vec;
    end
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    input  logic              en_rx,
    input  logic              en_tx,
    input  logic              en_err,
    input  logic              en_ovr,
    input  logic              err_stat,
    input  logic              bus_stat,
    input  logic              txbuf_free,
    input  logic              sleep_lvl,
    input  logic              rx_accept,
    input  logic              rx_release,
    input  logic              ovr_clear,
    output logic              rxbuf_status,
    output logic              data_ovr
);
    localparam int PAD_W = DATA_W - FLAG_W;

    logic [NLVL-1:0]   lvl, prev;
    logic [FLAG_W-1:0] set_vec, flags;
    logic              rd_hit, new_msg, ovr_ev, occ_full;

    always_comb begin
        lvl        = '0;
        lvl[L_ERR] = err_stat;
        lvl[L_BUS] = bus_stat;
        lvl[L_TXB] = txbuf_free;
        lvl[L_SLP] = sleep_lvl;
    end

    can_irq_lvl_hist #(.N(NLVL)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .prev (prev)
    );

    can_irq_rx_occ u_occ (
        .clk      (clk),
        .rst      (rst),
        .acc      (rx_accept),
        .rel      (rx_release),
        .ovr_clr  (ovr_clear),
        .new_msg  (new_msg),
        .ovr_ev   (ovr_ev),
        .full     (occ_full),
        .buf_stat (rxbuf_status),
        .dov_stat (data_ovr)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[B_RX]   = new_msg & en_rx;
        set_vec[B_TX]   = lvl[L_TXB] & ~prev[L_TXB] & en_tx;
        set_vec[B_ERR]  = ((lvl[L_ERR] ^ prev[L_ERR]) |
                           (lvl[L_BUS] ^ prev[L_BUS])) & en_err;
        set_vec[B_OVR]  = ovr_ev & en_ovr;
        set_vec[B_WAKE] = prev[L_SLP] & ~lvl[L_SLP];
    end

    assign rd_hit = cpu_rd && (cpu_addr == ADDR_W'(REG_ADDR));

    can_irq_flag_bank #(.W(FLAG_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .rd_hit  (rd_hit),
        .set_vec (set_vec),
        .flags   (flags)
    );

    assign rd_data = rd_hit ? {{PAD_W{1'b0}}, flags} : '0;
    assign irq     = |flags;
endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_hit,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [4:0] flags,
    input logic [4:0] set_vec,
    input logic       sleep_lvl,
    input logic       txbuf_free,
    input logic       en_tx,
    input logic       rx_accept,
    input logic       occ_full,
    input logic       rxbuf_status,
    input logic       data_ovr,
    input logic       ovr_clear
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (rd_data[7:5] == 3'b000));

    // R2
    irq_any_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && rd_data != 8'h00) |-> irq);

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && set_vec == 5'b0) |=> !irq);

    // R4
    wake_set_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(sleep_lvl)) |=> flags[4]);

    // R5
    tx_set_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(txbuf_free) && en_tx) |=> flags[1]);

    // R7
    rbs_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_accept |=> rxbuf_status);

    // R8
    ovr_dos_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_accept && occ_full) |=> data_ovr);

    // R12
    dos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ovr && !ovr_clear) |=> data_ovr);
endmodule

bind can_irq_flags can_irq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_hit       (rd_hit),
    .rd_data      (rd_data),
    .irq          (irq),
    .flags        (flags),
    .set_vec      (set_vec),
    .sleep_lvl    (sleep_lvl),
    .txbuf_free   (txbuf_free),
    .en_tx        (en_tx),
    .rx_accept    (rx_accept),
    .occ_full     (occ_full),
    .rxbuf_status (rxbuf_status),
    .data_ovr     (data_ovr),
    .ovr_clear    (ovr_clear)
);

// File: tb/sim_can_irq_flags.sv
`timescale 1ns/1ps
module sim_can_irq_flags;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_rd = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] rd_data;
    logic       irq;
    logic       en_rx = 0, en_tx = 0, en_err = 0, en_ovr = 0;
    logic       err_stat = 0, bus_stat = 0, txbuf_free = 0, sleep_lvl = 0;
    logic       rx_accept = 0, rx_release = 0, ovr_clear = 0;
    logic       rxbuf_status, data_ovr;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    can_irq_flags u0 (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .rd_data(rd_data), .irq(irq), .en_rx(en_rx), .en_tx(en_tx),
        .en_err(en_err), .en_ovr(en_ovr), .err_stat(err_stat),
        .bus_stat(bus_stat), .txbuf_free(txbuf_free), .sleep_lvl(sleep_lvl),
        .rx_accept(rx_accept), .rx_release(rx_release), .ovr_clear(ovr_clear),
        .rxbuf_status(rxbuf_status), .data_ovr(data_ovr)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        {en_rx, en_tx, en_err, en_ovr} = '0;
        {err_stat, bus_stat, txbuf_free, sleep_lvl} = '0;
        {rx_accept, rx_release, ovr_clear, cpu_rd} = '0;
        cpu_addr = 3'd0;
        rst = 1;
        tick();
        tick();
        rst = 0;
    endtask

    task automatic clear_rd();
        cpu_rd = 1; cpu_addr = 3'd3;
        tick();
        cpu_rd = 0;
    endtask

    task automatic read_chk(string req, logic [7:0] exp);
        cpu_rd = 1; cpu_addr = 3'd3;
        #1;
        check(req, rd_data, exp);
        tick();
        cpu_rd = 0;
    endtask

    initial begin
        do_reset();
        // R13 reset state
        check("R13 irq", {7'b0, irq}, 8'h00);
        check("R13 rbs", {7'b0, rxbuf_status}, 8'h00);
        check("R13 dos", {7'b0, data_ovr}, 8'h00);
        read_chk("R13 flags", 8'h00);

        // R6 error flag: all before/after pairs, enable on/off
        for (int e = 0; e < 32; e++) begin
            logic [1:0] p, n;
            logic       en;
            logic [7:0] exp;
            p = e[1:0]; n = e[3:2]; en = e[4];
            do_reset();
            en_err = en;
            err_stat = p[0]; bus_stat = p[1];
            tick();
            clear_rd();
            err_stat = n[0]; bus_stat = n[1];
            tick();
            exp = (en && (n != p)) ? 8'h04 : 8'h00;
            check("R2 irq err", {7'b0, irq}, {7'b0, exp != 0});
            read_chk("R6 err flag", exp);
            check("R3 cleared", {7'b0, irq}, 8'h00);
        end

        // R5 transmit flag
        for (int e = 0; e < 8; e++) begin
            logic p, n, en;
            p = e[0]; n = e[1]; en = e[2];
            do_reset();
            en_tx = en;
            txbuf_free = p;
            tick();
            clear_rd();
            txbuf_free = n;
            tick();
            read_chk("R5 tx flag", (en && !p && n) ? 8'h02 : 8'h00);
        end

        // R4 wake-up flag
        for (int e = 0; e < 4; e++) begin
            logic p, n;
            p = e[0]; n = e[1];
            do_reset();
            sleep_lvl = p;
            tick();
            clear_rd();
            sleep_lvl = n;
            tick();
            read_chk("R4 wake flag", (p && !n) ? 8'h10 : 8'h00);
        end

        // R7 R8 R9 R12 receive sequences
        for (int s = 0; s < 1024; s++) begin
            int cnt;
            bit rx_seen, ov_seen, dos;
            cnt = 0; rx_seen = 0; ov_seen = 0; dos = 0;
            do_reset();
            en_rx = s[8]; en_ovr = s[9];
            for (int k = 0; k < 4; k++) begin
                bit a, r;
                a = s[2*k]; r = s[2*k+1];
                if (a && cnt == 2) begin ov_seen = 1; dos = 1; end
                if (a && cnt < 2) rx_seen = 1;
                cnt = cnt + ((a && cnt < 2) ? 1 : 0) - ((r && cnt > 0) ? 1 : 0);
                rx_accept = a; rx_release = r;
                tick();
                check("R9 rbs", {7'b0, rxbuf_status}, {7'b0, cnt != 0});
                check("R8 dos", {7'b0, data_ovr}, {7'b0, dos});
            end
            rx_accept = 0; rx_release = 0;
            read_chk("R7 rx/ovr flags",
                     {4'b0, ov_seen & s[9], 2'b0, rx_seen & s[8]});
            check("R12 dos held", {7'b0, data_ovr}, {7'b0, dos});
            ovr_clear = 1;
            tick();
            ovr_clear = 0;
            check("R12 dos clear", {7'b0, data_ovr}, 8'h00);
        end

        // R10 set event coinciding with the clearing read
        do_reset();
        en_tx = 1;
        tick();
        txbuf_free = 1;
        read_chk("R11 old value", 8'h00);
        check("R10 irq kept", {7'b0, irq}, 8'h01);
        read_chk("R10 tx kept", 8'h02);

        // R11 read shows pre-clear value, wrong address ignored
        do_reset();
        en_tx = 1;
        tick();
        txbuf_free = 1;
        tick();
        cpu_rd = 1; cpu_addr = 3'd2;
        #1;
        check("R11 other addr", rd_data, 8'h00);
        tick();
        cpu_rd = 0;
        check("R11 not cleared", {7'b0, irq}, 8'h01);
        read_chk("R11 pre-clear", 8'h02);
        check("R3 irq low", {7'b0, irq}, 8'h00);

        // R1 all flags together, reserved bits zero
        do_reset();
        {en_rx, en_tx, en_err, en_ovr} = 4'hF;
        sleep_lvl = 1;
        tick();
        sleep_lvl = 0; err_stat = 1; txbuf_free = 1; rx_accept = 1;
        tick();
        tick();
        tick();
        rx_accept = 0;
        check("R2 irq all", {7'b0, irq}, 8'h01);
        read_chk("R1 layout", 8'h1F);

        // R13 reset after overrun
        rx_accept = 1;
        tick();
        rx_accept = 0;
        check("R8 dos set", {7'b0, data_ovr}, 8'h01);
        rst = 1;
        tick();
        rst = 0;
        check("R13 dos", {7'b0, data_ovr}, 8'h00);
        check("R13 rbs", {7'b0, rxbuf_status}, 8'h00);
        check("R13 irq", {7'b0, irq}, 8'h00);

        done = 1;
        summary();
        $finish;
    end
endmodule